// File: doc/BRIEF.md
# Byte-Grouped Digital I/O Port Controller

This block is a byte-addressed register block for a 32-line bidirectional digital port. The lines form four groups of eight. A host bus does single-byte reads and writes. Each group has its own data register. A write to a data register loads the group's output latch. A read of a data register returns the pad levels after a two-flop synchroniser.

Direction is chosen per group, never per line. Two control registers each hold an "is input" flag for two groups. A flag is loaded only by a write that sets the latch flag bit. A shared direction/enable register holds, for each group, an output-select bit and a buffer-disable bit. A group drives its pads only when all of these agree.

An identification byte reports a board code, which marks the digital port as present. The same byte reports which of the three module slots are empty. Software programs the port in a fixed order: the low control register, then the high control register, then the direction/enable register.

Top module: `dio_grouped_port`

## Requirements
- R1: After a synchronous reset, all 32 output enables and all output latches are 0. Both control registers read 0x12, which means every group is an input. The direction/enable register reads 0x00.
- R2: A control-register write (0x83 for groups 0/1, 0xC3 for groups 2/3) updates the input flags only when wdata bit 7 is 1. Bit 4 loads the lower group's input flag and bit 1 loads the upper group's input flag. A write with bit 7 clear changes nothing.
- R3: Group g drives its eight pads when three conditions hold: its output bit is set, its buffer-disable bit is clear, and its control input flag is clear. In the direction/enable register at 0x82, the output bits are 7, 6, 3 and 2 for groups 3, 2, 1 and 0. The buffer-disable bits are 5, 4, 1 and 0 for the same groups. Otherwise the group's pads are tri-stated.
- R4: A data-register write loads the group's output latch even while the group is an input. pad_out always shows the latches.
- R5: rdata updates only in the cycle after a read strobe. A data-register read returns the pad levels as they were three clock edges before the data appears, whatever the direction.
- R6: A read of 0x00 returns the board code in bits 4:0. Bits 7, 6 and 5 are 1 when slots 1, 2 and 3, respectively, are empty.
- R7: A read of an unmapped offset returns 0x00. A write to an unmapped offset changes no register.
- R8: Output enables are uniform within each group: all eight lines are enabled or none are.
- R9: The data registers for lines 0-7, 8-15, 16-23 and 24-31 are at offsets 0x80, 0x81, 0xC0 and 0xC1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Byte write strobe |
| bus_rd | input | 1 | Byte read strobe |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after bus_rd |
| slot_empty | input | 3 | Bit 0 = slot 1 empty, bit 1 = slot 2, bit 2 = slot 3 |
| pad_in | input | 32 | Pad input levels (asynchronous) |
| pad_out | output | 32 | Output latch values |
| pad_oe | output | 32 | Pad driver enables |

## Verification
The assertions check these properties on every cycle:
- the output enables stay uniform within each group;
- they never move without a bus write;
- a control write without the latch bit leaves the flags untouched;
- a data write appears on the latch one cycle later;
- read data holds between read strobes;
- an identification read returns the board code.

Some behaviour only the bench's scenarios can show, because it needs a reference model:
- the exact enable pattern produced by each combination of control and direction/enable writes;
- the three-edge read latency of synchronised pad levels;
- latch values that were preloaded while a group was an input and appear once the group is switched to output;
- unmapped offsets.

// File: rtl/dio_pkg.sv
package dio_pkg;

    localparam int GROUPS  = 4;
    localparam int GRP_W   = 8;
    localparam int LINES   = GROUPS * GRP_W;

    localparam logic [7:0] OFS_IDENT  = 8'h00;
    localparam logic [7:0] OFS_DATA0  = 8'h80;
    localparam logic [7:0] OFS_DATA1  = 8'h81;
    localparam logic [7:0] OFS_DATA2  = 8'hC0;
    localparam logic [7:0] OFS_DATA3  = 8'hC1;
    localparam logic [7:0] OFS_DIRENA = 8'h82;
    localparam logic [7:0] OFS_CTL_LO = 8'h83;
    localparam logic [7:0] OFS_CTL_HI = 8'hC3;

    localparam int CTL_LATCH_BIT = 7;
    localparam int CTL_LOWER_BIT = 4;
    localparam int CTL_UPPER_BIT = 1;

    typedef struct packed {
        logic       hit;
        logic [1:0] grp;
    } grp_sel_t;

    typedef struct packed {
        logic [GROUPS-1:0] out_sel;
        logic [GROUPS-1:0] buf_off;
    } dir_fields_t;

    function automatic grp_sel_t decode_data(input logic [7:0] a);
        grp_sel_t s;
        s.hit = 1'b1;
        s.grp = 2'd0;
        case (a)
            OFS_DATA0: s.grp = 2'd0;
            OFS_DATA1: s.grp = 2'd1;
            OFS_DATA2: s.grp = 2'd2;
            OFS_DATA3: s.grp = 2'd3;
            default:   s.hit = 1'b0;
        endcase
        return s;
    endfunction

    function automatic dir_fields_t split_dir(input logic [7:0] b);
        dir_fields_t f;
        f.out_sel = {b[7], b[6], b[3], b[2]};
        f.buf_off = {b[5], b[4], b[1], b[0]};
        return f;
    endfunction

    function automatic logic [7:0] pack_ctl(input logic lower_in, input logic upper_in);
        logic [7:0] v;
        v = 8'h00;
        v[CTL_LOWER_BIT] = lower_in;
        v[CTL_UPPER_BIT] = upper_in;
        return v;
    endfunction

endpackage

// File: rtl/dio_sync.sv
module dio_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [STAGES-1:0][WIDTH-1:0] chain;

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)
                    chain[s] <= '0;
                else if (s == 0)
                    chain[s] <= d_async;
                else
                    chain[s] <= chain[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/dio_host_regs.sv
module dio_host_regs
    import dio_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr,
    input  logic [7:0]                   addr,
    input  logic [7:0]                   wdata,
    output logic [GROUPS-1:0][GRP_W-1:0] latch,
    output logic [7:0]                   dir_byte,
    output logic [GROUPS-1:0]            grp_input
);
    grp_sel_t sel;
    assign sel = decode_data(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            latch     <= '0;
            dir_byte  <= 8'h00;
            grp_input <= '1;
        end else if (wr) begin
            if (sel.hit)
                latch[sel.grp] <= wdata;
            if (addr == OFS_DIRENA)
                dir_byte <= wdata;
            if (addr == OFS_CTL_LO && wdata[CTL_LATCH_BIT]) begin
                grp_input[0] <= wdata[CTL_LOWER_BIT];
                grp_input[1] <= wdata[CTL_UPPER_BIT];
            end
            if (addr == OFS_CTL_HI && wdata[CTL_LATCH_BIT]) begin
                grp_input[2] <= wdata[CTL_LOWER_BIT];
                grp_input[3] <= wdata[CTL_UPPER_BIT];
            end
        end
    end

    // R2: control write without the latch flag leaves input flags alone
    a_r2_latch_flag_needed: assert property (@(posedge clk) disable iff (rst)
        (wr && (addr == OFS_CTL_LO || addr == OFS_CTL_HI) && !wdata[CTL_LATCH_BIT])
        |=> $stable(grp_input));

    // R4: a data write lands in the matching latch one cycle later
    a_r4_latch_load: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == OFS_DATA0) |=> (latch[0] == $past(wdata)));
endmodule

// File: rtl/dio_grouped_port.sv
module dio_grouped_port
    import dio_pkg::*;
#(
    parameter logic [4:0] BOARD_CODE  = 5'h1D,
    parameter int         SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [7:0]       bus_addr,
    input  logic [7:0]       bus_wdata,
    output logic [7:0]       bus_rdata,
    input  logic [2:0]       slot_empty,
    input  logic [LINES-1:0] pad_in,
    output logic [LINES-1:0] pad_out,
    output logic [LINES-1:0] pad_oe
);
    logic [GROUPS-1:0][GRP_W-1:0] latch;
    logic [7:0]                   dir_byte;
    logic [GROUPS-1:0]            grp_input;
    logic [GROUPS-1:0][GRP_W-1:0] pad_sync;
    logic [LINES-1:0]             pad_sync_flat;
    dir_fields_t                  dir_f;
    grp_sel_t                     rd_sel;

    dio_host_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr        (bus_wr),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .latch     (latch),
        .dir_byte  (dir_byte),
        .grp_input (grp_input)
    );

    dio_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (pad_in),
        .q_sync  (pad_sync_flat)
    );
    assign pad_sync = pad_sync_flat;

    assign dir_f = split_dir(dir_byte);

    genvar g;
    generate
        for (g = 0; g < GROUPS; g++) begin : g_grp
            logic drive;
            assign drive = dir_f.out_sel[g] && !dir_f.buf_off[g] && !grp_input[g];
            assign pad_oe [g*GRP_W +: GRP_W] = {GRP_W{drive}};
            assign pad_out[g*GRP_W +: GRP_W] = latch[g];

            // R8: all eight enables of a group agree
            a_r8_group_uniform: assert property (@(posedge clk) disable iff (rst)
                ($countones(pad_oe[g*GRP_W +: GRP_W]) == 0) ||
                ($countones(pad_oe[g*GRP_W +: GRP_W]) == GRP_W));
        end
    endgenerate

    assign rd_sel = decode_data(bus_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= 8'h00;
        end else if (bus_rd) begin
            if (rd_sel.hit)
                bus_rdata <= pad_sync[rd_sel.grp];
            else begin
                case (bus_addr)
                    OFS_IDENT:  bus_rdata <= {slot_empty[0], slot_empty[1], slot_empty[2], BOARD_CODE};
                    OFS_DIRENA: bus_rdata <= dir_byte;
                    OFS_CTL_LO: bus_rdata <= pack_ctl(grp_input[0], grp_input[1]);
                    OFS_CTL_HI: bus_rdata <= pack_ctl(grp_input[2], grp_input[3]);
                    default:    bus_rdata <= 8'h00;
                endcase
            end
        end
    end

    // R3: driver enables only move after a bus write
    a_r3_oe_write_only: assert property (@(posedge clk) disable iff (rst)
        !$past(bus_wr) |-> $stable(pad_oe));

    // R5: read data holds between read strobes
    a_r5_rdata_hold: assert property (@(posedge clk) disable iff (rst)
        !$past(bus_rd) |-> $stable(bus_rdata));

    // R6: identification read carries the board code
    a_r6_ident_code: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == OFS_IDENT) |=> (bus_rdata[4:0] == BOARD_CODE));
endmodule

// File: tb/test_dio_grouped_port.sv
module test_dio_grouped_port;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = 8'h00, bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic [2:0]  slot_empty = 3'b101;
    logic [31:0] pad_in = 32'h0;
    logic [31:0] pad_out, pad_oe;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #4 clk = ~clk;   // 125 MHz

    dio_grouped_port i_dio_grouped_port (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .slot_empty(slot_empty), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    // behavioural reference model
    logic [7:0]  m_lat [4];
    logic [7:0]  m_dir;
    bit          m_in [4];
    logic [31:0] m_s1, m_s2;
    logic [7:0]  m_rd;

    function automatic logic [31:0] model_oe();
        logic [31:0] r = 0;
        int outb[4] = '{2, 3, 6, 7};
        int disb[4] = '{0, 1, 4, 5};
        for (int k = 0; k < 4; k++)
            if (m_dir[outb[k]] && !m_dir[disb[k]] && !m_in[k]) r[k*8 +: 8] = 8'hFF;
        return r;
    endfunction

    function automatic logic [31:0] model_out();
        return {m_lat[3], m_lat[2], m_lat[1], m_lat[0]};
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < 4; k++) begin m_lat[k] <= 0; m_in[k] <= 1; end
            m_dir <= 0; m_s1 <= 0; m_s2 <= 0; m_rd <= 0;
        end else begin
            m_s1 <= pad_in; m_s2 <= m_s1;
            if (bus_wr) begin
                case (bus_addr)
                    8'h80: m_lat[0] <= bus_wdata;
                    8'h81: m_lat[1] <= bus_wdata;
                    8'hC0: m_lat[2] <= bus_wdata;
                    8'hC1: m_lat[3] <= bus_wdata;
                    8'h82: m_dir <= bus_wdata;
                    8'h83: if (bus_wdata[7]) begin m_in[0] <= bus_wdata[4]; m_in[1] <= bus_wdata[1]; end
                    8'hC3: if (bus_wdata[7]) begin m_in[2] <= bus_wdata[4]; m_in[3] <= bus_wdata[1]; end
                    default: ;
                endcase
            end
            if (bus_rd) begin
                case (bus_addr)
                    8'h00: m_rd <= {slot_empty[0], slot_empty[1], slot_empty[2], 5'h1D};
                    8'h80: m_rd <= m_s2[7:0];
                    8'h81: m_rd <= m_s2[15:8];
                    8'hC0: m_rd <= m_s2[23:16];
                    8'hC1: m_rd <= m_s2[31:24];
                    8'h82: m_rd <= m_dir;
                    8'h83: m_rd <= {3'b0, m_in[0], 2'b0, m_in[1], 1'b0};
                    8'hC3: m_rd <= {3'b0, m_in[2], 2'b0, m_in[3], 1'b0};
                    default: m_rd <= 8'h00;
                endcase
            end
        end
        cycles <= cycles + 1;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one bus cycle: compare model at the falling edge, then drive
    task automatic step(input bit w, input bit r, input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        if (!rst) begin
            check(pad_oe  === model_oe(),  "R3 pad_oe",  pad_oe,  model_oe());
            check(pad_out === model_out(), "R4 pad_out", pad_out, model_out());
            check(bus_rdata === m_rd,      "R5 rdata",   {24'h0, bus_rdata}, {24'h0, m_rd});
        end
        bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d); step(1, 0, a, d); endtask
    task automatic idle(); step(0, 0, 8'h00, 8'h00); endtask

    task automatic rd_expect(input logic [7:0] a, input logic [7:0] e, input string req);
        step(0, 1, a, 8'h00);
        idle();
        check(bus_rdata === e, req, {24'h0, bus_rdata}, {24'h0, e});
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        wait (cycles > 20000);
        check(0, "watchdog", cycles, 20000);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        idle();
        // R1: reset state
        check(pad_oe === 32'h0 && pad_out === 32'h0, "R1 reset pads", pad_oe | pad_out, 0);
        rd_expect(8'h83, 8'h12, "R1 ctl lo");
        rd_expect(8'hC3, 8'h12, "R1 ctl hi");
        rd_expect(8'h82, 8'h00, "R1 direna");
        // R4: preload latches while inputs; R9 offsets
        wr(8'h80, 8'hA1); wr(8'h81, 8'hB2); wr(8'hC0, 8'hC3); wr(8'hC1, 8'hD4);
        idle();
        check(pad_out === 32'hD4C3B2A1, "R9 latch map", pad_out, 32'hD4C3B2A1);
        check(pad_oe === 32'h0, "R4 still input", pad_oe, 0);
        // R2: ignored without latch bit
        wr(8'h82, 8'hCC); wr(8'h83, 8'h00); wr(8'hC3, 8'h00); idle();
        check(pad_oe === 32'h0, "R2 no latch", pad_oe, 0);
        rd_expect(8'h83, 8'h12, "R2 ctl readback");
        // R3: groups 0 and 2 out, 1 and 3 in
        wr(8'h83, 8'h82); wr(8'hC3, 8'h82); wr(8'h82, 8'h44); idle();
        check(pad_oe === 32'h00FF00FF, "R3 g0 g2", pad_oe, 32'h00FF00FF);
        // R3: buffer disable group 0
        wr(8'h82, 8'h45); idle();
        check(pad_oe === 32'h00FF0000, "R3 bufdis", pad_oe, 32'h00FF0000);
        // R3/R8: all out
        wr(8'h83, 8'h80); wr(8'hC3, 8'h80); wr(8'h82, 8'hCC); idle();
        check(pad_oe === 32'hFFFFFFFF, "R8 all out", pad_oe, 32'hFFFFFFFF);
        // R5/R9: pad reads regardless of direction
        pad_in = 32'h12345678; repeat (3) idle();
        rd_expect(8'h80, 8'h78, "R9 rd g0");
        rd_expect(8'hC1, 8'h12, "R9 rd g3");
        wr(8'h83, 8'h92); idle();
        pad_in = 32'hCAFEF00D; repeat (3) idle();
        rd_expect(8'h80, 8'h0D, "R5 rd while input");
        rd_expect(8'hC0, 8'hFE, "R5 rd g2");
        // R5: latency, pad change then immediate read sees old value
        pad_in = 32'h000000AA;
        step(0, 1, 8'h80, 8'h00); idle();
        check(bus_rdata === 8'h0D, "R5 latency", {24'h0, bus_rdata}, 32'h0D);
        // R6
        rd_expect(8'h00, 8'hBD, "R6 ident");
        slot_empty = 3'b010; idle();
        rd_expect(8'h00, 8'h5D, "R6 ident slots");
        // R7: unmapped
        rd_expect(8'h40, 8'h00, "R7 unmapped rd");
        wr(8'h84, 8'hFF); wr(8'hC2, 8'h00); idle();
        rd_expect(8'h82, 8'hCC, "R7 unmapped wr");
        check(pad_out === 32'hD4C3B2A1, "R7 latches kept", pad_out, 32'hD4C3B2A1);
        repeat (4) idle();
        finish_run();
    end
endmodule